// File: doc/BRIEF.md
# Clock-Framed Serial-to-Parallel Receiver

This block receives a group of source-synchronous serial data lanes together with the clock that the transmitter forwards beside them. A fast bit clock, whose frequency is the forwarded clock frequency times the deserialization ratio, captures one bit per lane on every rising edge. The forwarded clock line is captured in the same way as a data lane. Its captured pattern is the only word-framing reference. While the receiver is unlocked, it moves the word boundary one bit at a time until the captured clock word shows the expected high-then-low shape. It then applies that same boundary to every data lane.

The ratio is a parameter from 2 to 8. Bits are captured by 4-bit shift stages. For ratios of five and above, a second stage is chained behind the first in a master/slave arrangement. Aligned words are held in the bit-clock domain. They are handed to the word clock, which runs at the forwarded clock rate and is derived from the same source as the bit clock. There they appear as registered outputs together with a lock flag.

Top module: `fcd_deser`

## Requirements
- R1: With parameter RATIO in 2..8, each word clock cycle presents one RATIO-bit word per lane on `par_data`, with lane l in bits [l*RATIO +: RATIO]. While locked, consecutive word clock cycles carry consecutive transmitted words with none skipped or repeated.
- R2: Capture uses 4-bit shift stages. When RATIO exceeds 4, a second stage is fed from the oldest bit of the first, so the second stage takes in, one bit clock later, the bit that leaves the first.
- R3: One bit per lane is sampled on each rising bit clock edge. The first bit received of a word lands in the most significant bit of that lane's field.
- R4: The forwarded clock line is assembled into a RATIO-bit word. The expected value has its upper ceil(RATIO/2) bits at 1 and the rest at 0, for example 1111000 at ratio 7 and 10 at ratio 2. While unlocked, each mismatching clock word stretches the next word period to RATIO+1 bit clocks, which moves the boundary one bit later. The first matching clock word sets the lock flag.
- R5: The boundary found on the forwarded clock line applies to every data lane at once, so all lanes are aligned to the same bit positions.
- R6: A single mismatching clock word while locked leaves the lock flag set and the boundary unchanged.
- R7: A second consecutive mismatching clock word clears the lock flag for that word. The search then resumes, and a following matching word sets the flag again.
- R8: A synchronous active-high reset, held across at least one word clock edge, clears the shift stages, the boundary counter, the lock flag and both output registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Fast capture clock, RATIO times the forwarded clock rate |
| word_clk | input | 1 | Slow word clock at the forwarded clock rate, phase-related to bit_clk |
| rst | input | 1 | Synchronous active-high reset for both clock domains |
| ser_data | input | LANES | Serial data lanes, one bit per lane per bit clock |
| ser_fwd_clk | input | 1 | Forwarded clock line, used as the framing reference |
| par_data | output | LANES*RATIO | Aligned parallel words, lane l in bits [l*RATIO +: RATIO] |
| par_locked | output | 1 | Set while the forwarded clock pattern is being recognised |

## Verification
Every ratio from 2 to 8 is swept, each starting from a random bit offset. If the boundary search slipped the wrong way or failed to stop, the design would never lock or would lock on a rotated word. The recovered words are then compared with the transmitted sequence on both lanes. A bit-order error or a cascade error at ratios above four would show up as bit-reversed or shifted words. So would a lane left on a different boundary. A single corrupted clock word must not disturb the lock, and a design that unlocks on one miss would show a gap. A pair of corrupted words must drop the lock for exactly one word and then regain it without a shift in the data. The reset state of the outputs is checked before any traffic arrives.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int STAGE_W   = 4;
  localparam int MAX_RATIO = 2 * STAGE_W;

  // Expected framing word: upper ceil(ratio/2) bits high, the rest low.
  function automatic logic [MAX_RATIO-1:0] frame_pattern(input int ratio);
    logic [MAX_RATIO-1:0] p;
    p = '0;
    for (int i = 0; i < MAX_RATIO; i++) begin
      if (i < ratio && i >= ratio / 2) p[i] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/fcd_shift_stage.sv
module fcd_shift_stage #(
  parameter int W = fcd_pkg::STAGE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [W-1:0] q
);

  // Newest bit enters at bit 0; the oldest sits at bit W-1.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/fcd_lane_capture.sv
module fcd_lane_capture #(
  parameter int RATIO = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [RATIO-1:0] word
);
  import fcd_pkg::*;

  localparam int NSTG = (RATIO > STAGE_W) ? 2 : 1;
  localparam int TOT  = NSTG * STAGE_W;

  logic [TOT-1:0]  chain;
  logic [NSTG:0]   link;

  assign link[0] = din;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    fcd_shift_stage #(.W(STAGE_W)) u_stage (
      .clk (clk),
      .rst (rst),
      .din (link[s]),
      .q   (chain[s*STAGE_W +: STAGE_W])
    );
    assign link[s+1] = chain[s*STAGE_W + STAGE_W - 1];
  end

  // Oldest captured bit of the window becomes the word MSB.
  assign word = chain[RATIO-1:0];

  logic unused_tail;
  assign unused_tail = link[NSTG];

  if (TOT > RATIO) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^chain[TOT-1:RATIO];
  end

  if (NSTG == 2) begin : g_cascade_chk
    // R2: slave stage takes in what left the master one bit clock earlier
    assert_cascade_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> chain[STAGE_W] == $past(chain[STAGE_W-1]))
      else $error("slave stage input does not follow master output");
  end

endmodule

// File: rtl/fcd_framer.sv
module fcd_framer #(
  parameter int RATIO = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RATIO-1:0] clk_word,
  output logic             strobe,
  output logic             locked
);
  import fcd_pkg::*;

  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [MAX_RATIO-1:0] EXP_FULL = frame_pattern(RATIO);

  logic [CW-1:0] cnt;
  logic          slip_hold;
  logic          miss;
  logic          pattern_ok;

  assign pattern_ok = (clk_word == EXP_FULL[RATIO-1:0]);
  assign strobe     = (cnt == LAST) && !slip_hold;

  // Word-phase counter; one held cycle stretches a period to RATIO+1 bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      slip_hold <= 1'b0;
    end else if (slip_hold) begin
      slip_hold <= 1'b0;
    end else if (cnt == LAST) begin
      cnt       <= '0;
      slip_hold <= !locked && !pattern_ok;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Lock tracking, evaluated once per word.
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      miss   <= 1'b0;
    end else if (strobe) begin
      if (pattern_ok) begin
        locked <= 1'b1;
        miss   <= 1'b0;
      end else if (locked) begin
        if (miss) begin
          locked <= 1'b0;
          miss   <= 1'b0;
        end else begin
          miss <= 1'b1;
        end
      end
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST)
    else $error("word phase counter out of range");

  assert_lock_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(strobe && pattern_ok))
    else $error("lock set without a matching clock word");

  assert_single_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && locked && !pattern_ok && !miss) |=> locked)
    else $error("lock lost after a single bad clock word");

  assert_unlock_two_miss_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(miss && strobe && !pattern_ok))
    else $error("lock dropped without two consecutive misses");

endmodule

// File: rtl/fcd_deser.sv
module fcd_deser #(
  parameter int LANES = 2,
  parameter int RATIO = 7
) (
  input  logic                   bit_clk,
  input  logic                   word_clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       ser_data,
  input  logic                   ser_fwd_clk,
  output logic [LANES*RATIO-1:0] par_data,
  output logic                   par_locked
);

  localparam int WORDS_W = LANES * RATIO;

  logic [RATIO-1:0]   fwd_word;
  logic [WORDS_W-1:0] lane_words;
  logic [WORDS_W-1:0] held;
  logic               strobe;
  logic               locked_f;

  fcd_lane_capture #(.RATIO(RATIO)) u_fwd_cap (
    .clk  (bit_clk),
    .rst  (rst),
    .din  (ser_fwd_clk),
    .word (fwd_word)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fcd_lane_capture #(.RATIO(RATIO)) u_cap (
      .clk  (bit_clk),
      .rst  (rst),
      .din  (ser_data[l]),
      .word (lane_words[l*RATIO +: RATIO])
    );
  end

  fcd_framer #(.RATIO(RATIO)) u_framer (
    .clk      (bit_clk),
    .rst      (rst),
    .clk_word (fwd_word),
    .strobe   (strobe),
    .locked   (locked_f)
  );

  // All lanes are latched on the strobe chosen from the forwarded clock.
  always_ff @(posedge bit_clk) begin
    if (rst)         held <= '0;
    else if (strobe) held <= lane_words;
  end

  // Handoff into the word clock domain.
  always_ff @(posedge word_clk) begin
    if (rst) begin
      par_data   <= '0;
      par_locked <= 1'b0;
    end else begin
      par_data   <= held;
      par_locked <= locked_f;
    end
  end

  assert_word_hold_R1: assert property (@(posedge bit_clk) disable iff (rst)
    !strobe |=> $stable(held))
    else $error("held word changed between strobes");

endmodule

// File: tb/fcd_deser_test.sv
module fcd_deser_test;

  localparam int CLK_PERIOD = 10;
  localparam int NRATIO     = 7;

  logic fclk = 1'b0;
  logic [NRATIO-1:0] sclk_v = '0;
  logic rst = 1'b1;
  int phase = 0;
  int errors = 0;
  int checks = 0;
  wire [NRATIO-1:0] fin_all;

  // Bit clock and all word clocks change together in one process.
  initial begin
    forever begin
      #(CLK_PERIOD/2);
      fclk = 1'b1;
      for (int r = 2; r <= 8; r++) sclk_v[r-2] = (phase % r) < ((r + 1) / 2);
      #(CLK_PERIOD/2);
      fclk = 1'b0;
      phase++;
    end
  end

  initial begin
    repeat (40) @(negedge fclk);
    rst = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  for (genvar g = 0; g < NRATIO; g++) begin : g_ratio
    localparam int R   = g + 2;
    localparam int NW  = 64;
    localparam int NRX = 100;
    localparam logic [R-1:0] EXP_PAT = R'(((1 << R) - 1) ^ ((1 << (R / 2)) - 1));

    logic [1:0]     sd = '0;
    logic           sf = 1'b0;
    logic [2*R-1:0] pd;
    logic           pl;
    logic           fin = 1'b0;
    logic [2*R-1:0] txw [NW];
    logic           rl  [NRX];
    logic [2*R-1:0] rd  [NRX];

    fcd_deser #(.LANES(2), .RATIO(R)) uut (
      .bit_clk     (fclk),
      .word_clk    (sclk_v[g]),
      .rst         (rst),
      .ser_data    (sd),
      .ser_fwd_clk (sf),
      .par_data    (pd),
      .par_locked  (pl)
    );

    assign fin_all[g] = fin;

    initial begin
      int  off, j0, k, w, bad_lock;
      bit  found, ok;
      for (int i = 0; i < NW; i++) txw[i] = (2*R)'($urandom);
      off = $urandom_range(2*R - 1, 0);
      @(negedge rst);
      chk(pl == 1'b0 && pd == '0, "R8",
          $sformatf("ratio %0d outputs after reset", R), {pd, pl}, 0);
      fork
        begin
          repeat (off) @(negedge fclk);
          for (int wi = 0; wi < NW; wi++) begin
            for (int b = R - 1; b >= 0; b--) begin
              @(negedge fclk);
              sf    = (wi == 20 || wi == 40 || wi == 41) ? !EXP_PAT[b] : EXP_PAT[b];
              sd[0] = txw[wi][b];
              sd[1] = txw[wi][R + b];
            end
          end
          @(negedge fclk);
          sf = 1'b0;
          sd = '0;
        end
        begin
          for (int j = 0; j < NRX; j++) begin
            @(negedge sclk_v[g]);
            rl[j] = pl;
            rd[j] = pd;
          end
        end
      join

      j0 = -1;
      for (int j = 0; j < NRX; j++) if (rl[j] && j0 < 0) j0 = j;
      chk(j0 >= 0, "R4", $sformatf("ratio %0d lock reached", R), j0, 0);

      found = 1'b0;
      k = 0;
      if (j0 >= 0 && j0 + 6 <= NRX) begin
        for (int m = 0; m + 6 <= NW; m++) begin
          if (!found) begin
            ok = 1'b1;
            for (int t = 0; t < 6; t++)
              if (!rl[j0+t] || rd[j0+t] != txw[m+t]) ok = 1'b0;
            if (ok) begin
              found = 1'b1;
              k = m - j0;
            end
          end
        end
      end
      chk(found, "R1", $sformatf("ratio %0d recovered word sequence", R), found, 1);

      if (found) begin
        chk(k + j0 < 20, "R4", $sformatf("ratio %0d lock before first bad word", R),
            k + j0, 20);
        bad_lock = 0;
        for (int j = 0; j < NRX; j++) begin
          w = k + j;
          if (w >= k + j0 && w < NW) begin
            if (w == 41)
              chk(!rl[j], "R7", $sformatf("ratio %0d lock cleared on second miss", R), rl[j], 0);
            else if (w == 42)
              chk(rl[j], "R7", $sformatf("ratio %0d relock after search", R), rl[j], 1);
            else if (w == 20)
              chk(rl[j], "R6", $sformatf("ratio %0d lock kept on single miss", R), rl[j], 1);
            else if (!rl[j])
              bad_lock++;
            if (rl[j]) begin
              chk(rd[j][R-1:0] == txw[w][R-1:0], (R > 4) ? "R2" : "R3",
                  $sformatf("ratio %0d lane0 word %0d", R, w), rd[j][R-1:0], txw[w][R-1:0]);
              chk(rd[j][2*R-1:R] == txw[w][2*R-1:R], "R5",
                  $sformatf("ratio %0d lane1 word %0d", R, w), rd[j][2*R-1:R], txw[w][2*R-1:R]);
            end
          end
        end
        chk(bad_lock == 0, "R4", $sformatf("ratio %0d lock held between disturbances", R),
            bad_lock, 0);
      end
      fin = 1'b1;
    end
  end

  initial begin
    fork
      begin
        wait (fin_all == {NRATIO{1'b1}});
      end
      begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule